// File: doc/BRIEF.md
# Quad Wiper Counter Controller

This block is the digital control core of a four-channel digital potentiometer. Each channel keeps an 8-bit wiper position and a small bank of four 8-bit stored settings. One shared parallel command port acts on one channel at a time. A command can do one of four things:

- set the wiper position directly,
- store a setting,
- copy a stored setting into the wiper,
- move the wiper one step up or one step down.

Every wiper position is decoded into a one-hot select over 256 taps, which drives the switches of the resistor array. The serial bus front end, nonvolatile storage and analog array sit outside this block.

After reset each wiper takes the value of its own stored setting 0. The stored settings come out of reset at a parameterised value, because no nonvolatile storage is modelled. Two combinational read ports return one wiper and one stored setting, chosen by their own select inputs.

Top module: `quad_wiper_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first clock cycle after it rises, `cmd_ready` is 0. Every wiper reads 0 during reset, and every stored setting reads the parameter `DREG_RST`. From the second cycle after release, `cmd_ready` is 1.
- R2: On the first clock edge after reset is released, every channel's wiper loads that channel's stored setting 0.
- R3: A command is accepted on a rising clock edge when both `cmd_valid` and `cmd_ready` are 1. At most one command is accepted per edge. Without an accepted command no wiper and no stored setting changes.
- R4: Opcode 2'b00 loads `cmd_data` into the wiper of channel `cmd_ch`. The new value is visible after that edge.
- R5: Opcode 2'b01 stores `cmd_data` into setting `cmd_reg` of channel `cmd_ch`. The wiper of every channel is left unchanged.
- R6: Opcode 2'b10 copies setting `cmd_reg` of channel `cmd_ch` into that channel's wiper in a single edge.
- R7: Opcode 2'b11 moves the wiper of channel `cmd_ch` by exactly one. It moves up when `cmd_up` is 1 and down when `cmd_up` is 0.
- R8: A step up at 0xFF leaves the wiper at 0xFF, and a step down at 0x00 leaves it at 0x00. The wiper never wraps around.
- R9: For channel c with wiper value v, bit c*256+v of `tap_sel` is 1 and the other 255 bits of slice c are 0. Value 0x00 selects the low-terminal tap (bit 0 of the slice), and 0xFF selects the high-terminal tap (bit 255).
- R10: A command on one channel changes neither the wiper nor the stored settings of the other channels.
- R11: `rd_wiper` shows the wiper of channel `rd_ch`, and `rd_dreg` shows setting `rd_reg` of channel `rd_ch`, both combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | Opcode: 00 wiper write, 01 setting write, 10 copy, 11 step |
| cmd_ch | input | 2 | Target channel |
| cmd_reg | input | 2 | Stored setting index |
| cmd_data | input | 8 | Write data |
| cmd_up | input | 1 | Step direction, 1 = up |
| rd_ch | input | 2 | Read-back channel |
| rd_reg | input | 2 | Read-back setting index |
| rd_wiper | output | 8 | Wiper of `rd_ch` |
| rd_dreg | output | 8 | Setting `rd_reg` of `rd_ch` |
| tap_sel | output | 1024 | One-hot tap select, 256 bits per channel |

## Verification
On every cycle the assertions check the following:

- the load after reset,
- the result of direct writes, copies and steps,
- saturation at both ends,
- that setting writes and idle cycles leave all wipers unchanged,
- that the tap select holds exactly one set bit per channel.

Only the bench scenarios can show the rest: that the right tap index is chosen, including the two terminal taps; that stored values read back; that other channels stay isolated; and that a non-default reset value reaches the wipers through the load after reset.

// File: rtl/quad_wiper_ctrl.sv
module quad_wiper_ctrl #(
  parameter int          NCH      = 4,
  parameter int          NREG     = 4,
  parameter int          W        = 8,
  parameter logic [7:0]  DREG_RST = 8'h00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [1:0]                  cmd_op,
  input  logic [$clog2(NCH)-1:0]      cmd_ch,
  input  logic [$clog2(NREG)-1:0]     cmd_reg,
  input  logic [W-1:0]                cmd_data,
  input  logic                        cmd_up,
  input  logic [$clog2(NCH)-1:0]      rd_ch,
  input  logic [$clog2(NREG)-1:0]     rd_reg,
  output logic [W-1:0]                rd_wiper,
  output logic [W-1:0]                rd_dreg,
  output logic [NCH*(1<<W)-1:0]       tap_sel
);
  localparam int          TAPS  = 1 << W;
  localparam logic [W-1:0] WMAX = {W{1'b1}};
  localparam logic [1:0]  OP_WR   = 2'b00;
  localparam logic [1:0]  OP_DREG = 2'b01;
  localparam logic [1:0]  OP_XFR  = 2'b10;
  localparam logic [1:0]  OP_STEP = 2'b11;

  logic [NCH-1:0][W-1:0]            wiper_q;
  logic [NCH-1:0][NREG-1:0][W-1:0]  dreg_q;
  logic                             init_q;
  logic                             fire;

  assign cmd_ready = rst_n && !init_q;
  assign fire      = cmd_valid && cmd_ready;
  assign rd_wiper  = wiper_q[rd_ch];
  assign rd_dreg   = dreg_q[rd_ch][rd_reg];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= 1'b1;
      wiper_q <= '0;
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < NREG; r++)
          dreg_q[c][r] <= DREG_RST[W-1:0];
    end else if (init_q) begin
      init_q <= 1'b0;
      for (int c = 0; c < NCH; c++)
        wiper_q[c] <= dreg_q[c][0];
    end else if (fire) begin
      case (cmd_op)
        OP_WR:   wiper_q[cmd_ch] <= cmd_data;
        OP_DREG: dreg_q[cmd_ch][cmd_reg] <= cmd_data;
        OP_XFR:  wiper_q[cmd_ch] <= dreg_q[cmd_ch][cmd_reg];
        default: begin
          if (cmd_up && wiper_q[cmd_ch] != WMAX)
            wiper_q[cmd_ch] <= wiper_q[cmd_ch] + 1'b1;
          else if (!cmd_up && wiper_q[cmd_ch] != '0)
            wiper_q[cmd_ch] <= wiper_q[cmd_ch] - 1'b1;
        end
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_tap
    assign tap_sel[c*TAPS +: TAPS] = {{(TAPS-1){1'b0}}, 1'b1} << wiper_q[c];

    a_r9_one_tap: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel[c*TAPS +: TAPS]) == 1);
  end

  a_r2_powerup_load: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> wiper_q[0] == $past(dreg_q[0][0]) && wiper_q[NCH-1] == $past(dreg_q[NCH-1][0]));

  a_r4_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_WR) |=> wiper_q[$past(cmd_ch)] == $past(cmd_data));

  a_r6_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_XFR) |=> wiper_q[$past(cmd_ch)] == $past(dreg_q[cmd_ch][cmd_reg]));

  a_r7_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_STEP && cmd_up && wiper_q[cmd_ch] != WMAX)
      |=> wiper_q[$past(cmd_ch)] == $past(wiper_q[cmd_ch]) + 1'b1);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_STEP && cmd_up && wiper_q[cmd_ch] == WMAX)
      |=> wiper_q[$past(cmd_ch)] == WMAX);

  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_STEP && !cmd_up && wiper_q[cmd_ch] == '0)
      |=> wiper_q[$past(cmd_ch)] == '0);

  a_r5_store_keeps_wiper: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == OP_DREG) |=> $stable(wiper_q));

  a_r3_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !init_q) |=> $stable(wiper_q) && $stable(dreg_q));
endmodule

// File: tb/quad_wiper_ctrl_bench.sv
module quad_wiper_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [1:0]   cmd_op = '0;
  logic [1:0]   cmd_ch = '0;
  logic [1:0]   cmd_reg = '0;
  logic [7:0]   cmd_data = '0;
  logic         cmd_up = 1'b0;
  logic [1:0]   rd_ch = '0;
  logic [1:0]   rd_reg = '0;
  logic [7:0]   rd_wiper;
  logic [7:0]   rd_dreg;
  logic [1023:0] tap_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_w [4];

  always #5 clk = ~clk;

  quad_wiper_ctrl #(.DREG_RST(8'h5A)) u_quad_wiper_ctrl (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_ch, .cmd_reg,
    .cmd_data, .cmd_up, .rd_ch, .rd_reg, .rd_wiper, .rd_dreg, .tap_sel);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] ch, input logic [1:0] rg,
                       input logic [7:0] d, input logic up);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch; cmd_reg = rg; cmd_data = d; cmd_up = up;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic chk_wipers(input string tag);
    for (int c = 0; c < 4; c++) begin
      rd_ch = c[1:0];
      #1;
      chk(tag, rd_wiper, exp_w[c]);
      chk({tag, " tap"}, {31'd0, tap_sel[c*256 + exp_w[c]]}, 1);
      chk({tag, " tapcount"}, $countones(tap_sel[c*256 +: 256]), 1);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ready in reset", cmd_ready, 0);
    rd_ch = 2'd3; rd_reg = 2'd2; #1;
    chk("R1 dreg reset value", rd_dreg, 8'h5A);
    chk("R1 wiper in reset", rd_wiper, 0);
    rst_n = 1'b1;
    #1;
    chk("R1 ready first cycle", cmd_ready, 0);
    @(negedge clk);
    chk("R1 ready after load", cmd_ready, 1);
    for (int c = 0; c < 4; c++) exp_w[c] = 8'h5A;
    chk_wipers("R2 power-up load");
  endtask

  task automatic t_direct;
    issue(2'b00, 2'd0, 2'd0, 8'h10, 1'b0); exp_w[0] = 8'h10;
    issue(2'b00, 2'd1, 2'd0, 8'h80, 1'b0); exp_w[1] = 8'h80;
    issue(2'b00, 2'd2, 2'd0, 8'h00, 1'b0); exp_w[2] = 8'h00;
    issue(2'b00, 2'd3, 2'd0, 8'hFF, 1'b0); exp_w[3] = 8'hFF;
    chk_wipers("R4 R9 R10 direct write");
    chk("R9 low terminal", {31'd0, tap_sel[2*256]}, 1);
    chk("R9 high terminal", {31'd0, tap_sel[3*256 + 255]}, 1);
  endtask

  task automatic t_store;
    issue(2'b01, 2'd1, 2'd2, 8'hC3, 1'b0);
    rd_ch = 2'd1; rd_reg = 2'd2; #1;
    chk("R5 stored value", rd_dreg, 8'hC3);
    rd_ch = 2'd2; #1;
    chk("R10 other channel setting", rd_dreg, 8'h5A);
    chk_wipers("R5 wiper unchanged");
  endtask

  task automatic t_copy;
    issue(2'b10, 2'd1, 2'd2, 8'h00, 1'b0); exp_w[1] = 8'hC3;
    issue(2'b10, 2'd0, 2'd0, 8'h77, 1'b0); exp_w[0] = 8'h5A;
    chk_wipers("R6 copy");
  endtask

  task automatic t_step;
    issue(2'b00, 2'd0, 2'd0, 8'h10, 1'b0); exp_w[0] = 8'h10;
    issue(2'b11, 2'd0, 2'd0, 8'h00, 1'b1); exp_w[0] = 8'h11;
    chk_wipers("R7 step up");
    issue(2'b11, 2'd0, 2'd0, 8'h00, 1'b0);
    issue(2'b11, 2'd0, 2'd0, 8'h00, 1'b0); exp_w[0] = 8'h0F;
    chk_wipers("R7 step down");
  endtask

  task automatic t_sat;
    issue(2'b11, 2'd3, 2'd0, 8'h00, 1'b1);
    issue(2'b11, 2'd2, 2'd0, 8'h00, 1'b0);
    chk_wipers("R8 saturate");
    issue(2'b11, 2'd3, 2'd0, 8'h00, 1'b0); exp_w[3] = 8'hFE;
    issue(2'b11, 2'd2, 2'd0, 8'h00, 1'b1); exp_w[2] = 8'h01;
    chk_wipers("R8 leave ends");
  endtask

  task automatic t_idle;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_ch = 2'd1; cmd_data = 8'h33;
    repeat (3) @(negedge clk);
    chk_wipers("R3 no valid no change");
    rd_ch = 2'd1; rd_reg = 2'd2; #1;
    chk("R11 R3 setting kept", rd_dreg, 8'hC3);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_direct();
    t_store();
    t_copy();
    t_step();
    t_sat();
    t_idle();
    finish_run();
  end
endmodule